// File: doc/BRIEF.md
# Per-Branch History Direction Predictor

This block guesses whether a conditional branch will be taken, using only that branch's own recent outcomes. A first-level table, selected by a few low bits of the branch address, keeps a short shift register of past outcomes for each branch slot. The bits of that register select one entry in a second-level table of 2-bit saturating counters. The upper bit of the selected counter is the guess. The same branch therefore learns a separate answer for each pattern of its own past behaviour, rather than one answer for its address.

The fetch side presents a PC and receives the guess, together with the counter index it used. When the branch resolves, the back end returns the PC, the real outcome and that saved index. The block trains the counter at the saved index and shifts the outcome into the branch's history slot. After reset a sweep state machine first writes every history and counter. It has two states. `ST_SWEEP` is entered on reset and walks one entry of each table per cycle. `ST_RUN` is entered from `ST_SWEEP` on the cycle the sweep index reaches its last value, and it holds until the next reset. The output `ready` is high only in `ST_RUN`.

Top module: `local_hist_predictor`

## Requirements
- R1: After reset is released, `ready` stays low for exactly max(2^PC_IDX_W, 2^HIST_W) rising clock edges, then goes high and stays high until the next reset.
- R2: While `ready` is low, `pred_taken` is 0 and `upd_en` has no effect on any history or counter.
- R3: The history slot is chosen by PC bits [ALIGN_W +: PC_IDX_W]. `pred_idx` shows that slot's history in the same cycle that `pred_pc` is presented.
- R4: `pred_taken` is bit 1 of the counter selected by `pred_idx`. Counter values 2 and 3 predict taken, and 0 and 1 predict not taken.
- R5: When the sweep completes, every history is all zeros and every counter holds 1 (weakly not taken). This holds after each reset.
- R6: An update moves the counter at `upd_idx` up by one when `upd_taken` is 1, stopping at 3. It moves the counter down by one when `upd_taken` is 0, stopping at 0.
- R7: An update shifts the history of the slot chosen by `upd_pc` left by one. `upd_taken` enters at bit 0 and the oldest bit is dropped.
- R8: An update changes only the one counter and the one history slot it addresses. Two PCs that differ only outside the index bits share a slot.
- R9: When an update and a prediction touch the same entries in one cycle, the prediction returns the values from before the update.
- R10: The counter that an update trains is the one at `upd_idx`, even when the branch's current history is different.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the sweep |
| ready | output | 1 | High once both tables are initialised |
| pred_pc | input | PC_W | Address of the branch to predict |
| pred_taken | output | 1 | Guessed direction, 1 = taken |
| pred_idx | output | HIST_W | Counter index used for this guess |
| upd_en | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_idx | input | HIST_W | Counter index saved at prediction time |

## Verification
The bench builds the block with PC_W=16, ALIGN_W=2, PC_IDX_W=3 and HIST_W=4. That gives 8 history slots and 16 counters, so the sweep lasts 16 edges and can be counted edge by edge. With 4-bit histories, a run of four equal outcomes fills a history completely, which brings counter saturation at both ends within reach after a few updates. Address aliasing (R8) can also be exercised with PCs that differ in bit 5 and above. A stored-index update that disagrees with the current history (R10) is tested, and so is the restoration of trained counters on a second reset (R5).

// File: rtl/lhp_pkg.sv
package lhp_pkg;

    typedef enum logic [0:0] {
        ST_SWEEP = 1'b0,
        ST_RUN   = 1'b1
    } lhp_state_e;

    localparam logic [1:0] CTR_INIT = 2'd1;

    // saturating 2-bit step toward the resolved direction
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) begin
            nxt = (cur == 2'd3) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == 2'd0) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lhp_init_fsm.sv
module lhp_init_fsm
    import lhp_pkg::*;
#(
    parameter int unsigned SWP_N = 1024,
    localparam int unsigned SWP_W = (SWP_N > 1) ? $clog2(SWP_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sweep_en,
    output logic [SWP_W-1:0] sweep_idx,
    output logic             ready
);

    localparam logic [SWP_W-1:0] LAST_IDX = SWP_W'(SWP_N - 1);

    lhp_state_e       state_q, state_d;
    logic [SWP_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SWEEP: begin
                if (cnt_q == LAST_IDX) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_SWEEP;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        sweep_en  = 1'b0;
        ready     = 1'b0;
        sweep_idx = cnt_q;
        unique case (state_q)
            ST_SWEEP: sweep_en = 1'b1;
            ST_RUN:   ready    = 1'b1;
            default:  sweep_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned HIST_W = 10,
    localparam int unsigned ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit
);

    logic [HIST_W-1:0] slot [ENTRIES];

    assign rd_hist = slot[rd_idx];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            slot[clr_idx] <= '0;
        end else if (wr_en) begin
            slot[wr_idx] <= (slot[wr_idx] << 1) | HIST_W'(wr_bit);
        end
    end

endmodule

// File: rtl/lhp_ctr_table.sv
module lhp_ctr_table
    import lhp_pkg::*;
#(
    parameter int unsigned IDX_W = 10,
    localparam int unsigned ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    logic [1:0] ctr [ENTRIES];

    assign rd_ctr = ctr[rd_idx];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            ctr[clr_idx] <= CTR_INIT;
        end else if (wr_en) begin
            ctr[wr_idx] <= ctr_step(ctr[wr_idx], wr_taken);
        end
    end

endmodule

// File: rtl/local_hist_predictor.sv
module local_hist_predictor
    import lhp_pkg::*;
#(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned ALIGN_W  = 2,
    parameter int unsigned PC_IDX_W = 6,
    parameter int unsigned HIST_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ready,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_idx,
    input  logic              upd_en,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_idx
);

    localparam int unsigned L1_N  = 1 << PC_IDX_W;
    localparam int unsigned L2_N  = 1 << HIST_W;
    localparam int unsigned SWP_N = max_u(L1_N, L2_N);
    localparam int unsigned SWP_W = (SWP_N > 1) ? $clog2(SWP_N) : 1;

    logic             sweep_en;
    logic [SWP_W-1:0] sweep_idx;
    logic             run;
    logic             l1_clr, l2_clr;
    logic             upd_live;
    logic [1:0]       sel_ctr;
    logic [PC_IDX_W-1:0] pred_slot, upd_slot;

    assign pred_slot = pred_pc[ALIGN_W +: PC_IDX_W];
    assign upd_slot  = upd_pc[ALIGN_W +: PC_IDX_W];

    lhp_init_fsm #(.SWP_N(SWP_N)) i_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep_en  (sweep_en),
        .sweep_idx (sweep_idx),
        .ready     (run)
    );

    assign l1_clr   = sweep_en && ({1'b0, sweep_idx} < (SWP_W + 1)'(L1_N));
    assign l2_clr   = sweep_en && ({1'b0, sweep_idx} < (SWP_W + 1)'(L2_N));
    assign upd_live = run && upd_en;

    lhp_hist_table #(.IDX_W(PC_IDX_W), .HIST_W(HIST_W)) i_hist (
        .clk     (clk),
        .clr_en  (l1_clr),
        .clr_idx (sweep_idx[PC_IDX_W-1:0]),
        .rd_idx  (pred_slot),
        .rd_hist (pred_idx),
        .wr_en   (upd_live),
        .wr_idx  (upd_slot),
        .wr_bit  (upd_taken)
    );

    lhp_ctr_table #(.IDX_W(HIST_W)) i_ctr (
        .clk      (clk),
        .clr_en   (l2_clr),
        .clr_idx  (sweep_idx[HIST_W-1:0]),
        .rd_idx   (pred_idx),
        .rd_ctr   (sel_ctr),
        .wr_en    (upd_live),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    assign ready      = run;
    assign pred_taken = run && sel_ctr[1];

endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned ALIGN_W  = 2,
    parameter int unsigned PC_IDX_W = 6,
    parameter int unsigned HIST_W   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic [PC_W-1:0]   pred_pc,
    input logic              pred_taken,
    input logic [HIST_W-1:0] pred_idx,
    input logic              upd_en,
    input logic [PC_W-1:0]   upd_pc,
    input logic              upd_taken,
    input logic [HIST_W-1:0] upd_idx
);

    logic [PC_IDX_W-1:0] p_slot, u_slot;
    assign p_slot = pred_pc[ALIGN_W +: PC_IDX_W];
    assign u_slot = upd_pc[ALIGN_W +: PC_IDX_W];

    // R1
    assert_ready_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R2
    assert_no_guess_in_sweep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !pred_taken);

    // R7
    assert_hist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && upd_en && p_slot == u_slot) |=>
        ((p_slot != $past(p_slot)) ||
         (pred_idx == HIST_W'({$past(pred_idx), $past(upd_taken)}))));

    // R8
    assert_quiet_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready) && !$past(upd_en) && $stable(pred_pc)) |->
        ($stable(pred_idx) && $stable(pred_taken)));

    logic unused_ok;
    assign unused_ok = ^upd_idx;

endmodule

bind local_hist_predictor lhp_checker #(
    .PC_W(PC_W), .ALIGN_W(ALIGN_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W)
) i_lhp_checker (
    .clk(clk), .rst_n(rst_n), .ready(ready), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_idx(pred_idx), .upd_en(upd_en),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_idx(upd_idx)
);

// File: tb/test_local_hist_predictor.sv
`timescale 1ns/1ps
module test_local_hist_predictor;

    localparam int PC_W = 16, ALIGN_W = 2, PC_IDX_W = 3, HIST_W = 4;
    localparam int L1_N = 8, L2_N = 16, SWP_N = 16;
    localparam int VEC_N = 24;

    // {pc, taken}
    localparam logic [16:0] VEC [VEC_N] = '{
        {16'h0010, 1'b1}, {16'h0010, 1'b1}, {16'h0024, 1'b0}, {16'h0010, 1'b1},
        {16'h0110, 1'b1}, {16'h0010, 1'b1}, {16'h0010, 1'b1}, {16'h0010, 1'b1},
        {16'h001C, 1'b1}, {16'h001C, 1'b0}, {16'h001C, 1'b1}, {16'h001C, 1'b0},
        {16'h0024, 1'b0}, {16'h0024, 1'b0}, {16'h0024, 1'b0}, {16'h0024, 1'b0},
        {16'h0010, 1'b0}, {16'h0010, 1'b0}, {16'h0210, 1'b0}, {16'h0010, 1'b0},
        {16'h0010, 1'b0}, {16'h0010, 1'b1}, {16'h003C, 1'b1}, {16'h0010, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ready;
    logic [PC_W-1:0] pred_pc = '0;
    logic pred_taken;
    logic [HIST_W-1:0] pred_idx;
    logic upd_en = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic upd_taken = 1'b0;
    logic [HIST_W-1:0] upd_idx = '0;

    int n_run = 0;
    int n_fail = 0;

    logic [HIST_W-1:0] hist_m [L1_N];
    logic [1:0]        ctr_m  [L2_N];

    always #2 clk = ~clk;

    local_hist_predictor #(
        .PC_W(PC_W), .ALIGN_W(ALIGN_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W)
    ) i_local_hist_predictor (
        .clk(clk), .rst_n(rst_n), .ready(ready), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_idx(pred_idx), .upd_en(upd_en),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_idx(upd_idx)
    );

    function automatic int slot_of(input logic [PC_W-1:0] pc);
        return int'(pc[ALIGN_W +: PC_IDX_W]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < L1_N; i++) hist_m[i] = '0;
        for (int i = 0; i < L2_N; i++) ctr_m[i] = 2'd1;
    endtask

    // reset, then count the sweep edge by edge while hammering updates
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        for (int k = 0; k < SWP_N; k++) begin
            upd_en = 1'b1; upd_pc = '0; upd_idx = '0; upd_taken = 1'b1;
            pred_pc = '0;
            #1;
            check(ready == 1'b0, "R1 ready low during sweep", ready, 0);
            check(pred_taken == 1'b0, "R2 no taken guess during sweep", pred_taken, 0);
            @(posedge clk);
            @(negedge clk);
        end
        upd_en = 1'b0;
        #1;
        check(ready == 1'b1, "R1 ready after sweep", ready, 1);
    endtask

    task automatic probe(input logic [PC_W-1:0] pc, input string req);
        @(negedge clk);
        upd_en = 1'b0;
        pred_pc = pc;
        #1;
        check(pred_idx == hist_m[slot_of(pc)], {req, " history"}, pred_idx, hist_m[slot_of(pc)]);
        check(pred_taken == ctr_m[hist_m[slot_of(pc)]][1], {req, " guess"},
              pred_taken, ctr_m[hist_m[slot_of(pc)]][1]);
    endtask

    // predict and update the same branch in one cycle
    task automatic step(input logic [PC_W-1:0] pc, input logic t,
                        input bit own, input logic [HIST_W-1:0] own_idx);
        logic [HIST_W-1:0] e_idx;
        logic [HIST_W-1:0] w_idx;
        @(negedge clk);
        e_idx = hist_m[slot_of(pc)];
        w_idx = own ? own_idx : e_idx;
        pred_pc = pc; upd_pc = pc; upd_taken = t; upd_idx = w_idx; upd_en = 1'b1;
        #1;
        check(pred_idx == e_idx, "R9 R3 pre-update history", pred_idx, e_idx);
        check(pred_taken == ctr_m[e_idx][1], "R9 R4 pre-update guess",
              pred_taken, ctr_m[e_idx][1]);
        @(posedge clk);
        if (t) ctr_m[w_idx] = (ctr_m[w_idx] == 2'd3) ? 2'd3 : ctr_m[w_idx] + 2'd1;
        else   ctr_m[w_idx] = (ctr_m[w_idx] == 2'd0) ? 2'd0 : ctr_m[w_idx] - 2'd1;
        hist_m[slot_of(pc)] = {hist_m[slot_of(pc)][HIST_W-2:0], t};
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        #1;
        check(ready == 1'b0, "R1 ready low in reset", ready, 0);
        do_reset();

        // R5 R2: clean tables despite updates strobed during the sweep
        for (int p = 0; p < L1_N; p++) probe(PC_W'(p << ALIGN_W), "R5 R2 post-sweep");

        // R6 R7 R8 R9: table of outcomes
        for (int i = 0; i < VEC_N; i++) step(VEC[i][16:1], VEC[i][0], 1'b0, '0);
        for (int p = 0; p < L1_N; p++) probe(PC_W'(p << ALIGN_W), "R8 R7 slot state");
        probe(16'h0410, "R8 alias slot");

        // R10: train a stored index that differs from the history
        for (int k = 0; k < 4; k++) step(16'h0008, 1'b1, 1'b1, 4'd5);
        probe(16'h0008, "R10 full history");
        for (int k = 0; k < 3; k++) step(16'h000C, 1'b0, 1'b1, 4'd5);
        step(16'h000C, 1'b1, 1'b1, 4'd5);
        step(16'h000C, 1'b1, 1'b1, 4'd5);
        probe(16'h000C, "R10 R6 saturated stored index");

        // R5: second reset restores trained state
        do_reset();
        for (int k = 0; k < 4; k++) step(16'h0008, 1'b1, 1'b1, 4'd3);
        probe(16'h0008, "R5 counter restored");
        for (int k = 0; k < 3; k++) step(16'h0014, 1'b0, 1'b0, '0);
        probe(16'h0014, "R6 floor at zero");

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule